// File: doc/BRIEF.md
# UART Modem Line Control with Loopback and Clear-to-Send Gating

This block sits between a UART transmitter, a UART receiver and the four modem-side pins: receive data, transmit data, request-to-send and clear-to-send. It decides the serial input the receiver sees and the level driven on the request-to-send pin. It also reports the current clear-to-send status and a sticky change flag, and it decides when the transmitter may move a character from its holding register into its shift register.

The pin polarity is programmable. With `pol_hi` at 0 both handshake pins are active low, and with `pol_hi` at 1 they are active high. The external clear-to-send pin passes through a synchronizer of `SYNC_STAGES` flops before the polarity is applied.

In loopback mode the receiver is fed from the transmitter's own serial output, and the external receive pin is ignored. The transmit pin keeps driving data. The request-to-send pin is held at its inactive level. The manual request-to-send bit takes the place of the clear-to-send input, so software can throttle its own transmitter.

Transfer gating is done by a three-state machine:

- `ST_IDLE`: the shift register is empty.
- `ST_BLOCKED`: a character waits in the holding register while clear-to-send is inactive and automatic gating is on.
- `ST_SHIFT`: a frame is in the shift register.

The machine has four transitions:

- **launch** (`ST_IDLE` to `ST_SHIFT`): a character waits and the path is clear.
- **stall** (`ST_IDLE` to `ST_BLOCKED`): a character waits and the path is not clear.
- **release** (`ST_BLOCKED` to `ST_SHIFT`): the path becomes clear.
- **finish** (`ST_SHIFT` to `ST_IDLE`): `shift_done` is seen.

`xfer_go` is high in the cycle of a launch or a release.

Top module: `uart_modem_ctl`

## Requirements
- R1: With `lpbk_en`=1, `rx_ser` equals `tx_ser` and `rx_pin` has no effect. With `lpbk_en`=0, `rx_ser` equals `rx_pin`.
- R2: `tx_pin` always equals `tx_ser`, in loopback mode as well.
- R3: With `lpbk_en`=1, `rts_pin` sits at its inactive level, which is 1 when `pol_hi`=0 and 0 when `pol_hi`=1. With `lpbk_en`=0, `rts_pin` is driven to its active level (0 when `pol_hi`=0, 1 when `pol_hi`=1) exactly when `man_rts`=1.
- R4: With `lpbk_en`=0, `cts_stat` is 1 when the synchronized `cts_pin` sits at its active level (low for `pol_hi`=0, high for `pol_hi`=1). A pin change shows on `cts_stat` after `SYNC_STAGES` rising clock edges. With `lpbk_en`=1, `cts_stat` equals `man_rts` in the same cycle.
- R5: With `auto_cts`=0, a waiting character (`hold_valid`=1) in `ST_IDLE` gives `xfer_go`=1 in that cycle, whatever the clear-to-send value.
- R6: With `auto_cts`=1 and `cts_stat`=0, `xfer_go` stays 0 and a waiting character stays held, with the machine in `ST_BLOCKED`.
- R7: In `ST_BLOCKED`, `xfer_go` rises in the same cycle that `cts_stat` becomes 1. In loopback mode, writing 1 to `man_rts` therefore starts the transmitter.
- R8: Once `xfer_go` has fired, `tx_active` is 1 from the next edge until the edge that samples `shift_done`=1, even if clear-to-send drops meanwhile.
- R9: `dcts_stat` becomes 1 on the edge after any change of `cts_stat` and stays 1 until an edge with `dcts_clr`=1. A change seen on the same edge as a clear wins, leaving `dcts_stat`=1.
- R10: After reset, `xfer_go`=0, `tx_active`=0 and `dcts_stat`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpbk_en | input | 1 | Loopback enable |
| man_rts | input | 1 | Manual request-to-send control bit |
| auto_cts | input | 1 | Enable clear-to-send transmit gating |
| pol_hi | input | 1 | Handshake pin polarity: 1 = active high |
| dcts_clr | input | 1 | Clear pulse for the clear-to-send change flag |
| cts_pin | input | 1 | Raw clear-to-send pin (asynchronous) |
| rx_pin | input | 1 | External receive data pin |
| tx_ser | input | 1 | Transmitter serial output |
| hold_valid | input | 1 | Transmit holding register has a character |
| shift_done | input | 1 | Transmit shift register finished its frame |
| rx_ser | output | 1 | Serial input to the receiver |
| tx_pin | output | 1 | External transmit data pin |
| rts_pin | output | 1 | External request-to-send pin |
| xfer_go | output | 1 | Permit holding-to-shift transfer this cycle |
| tx_active | output | 1 | A frame is in the shift register |
| cts_stat | output | 1 | Effective clear-to-send status |
| dcts_stat | output | 1 | Sticky clear-to-send change flag |

## Verification
The bench builds the block with `SYNC_STAGES`=2. This makes the pin-to-status delay a fixed two edges, which the bench counts exactly.

With that setting, every combination of loopback, polarity, manual request-to-send, clear-to-send pin, receive pin and transmit data (64 in all) can be swept. Each combination is compared with routing and polarity levels worked out arithmetically in the bench.

Directed sequences then walk the machine through every transition. These sequences cover:

- gating driven both through loopback and through the real pin with one-edge-early sampling;
- a frame that completes after clear-to-send drops;
- the change flag with its set-wins-over-clear corner.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_SHIFT   = 2'd2
    } gate_st_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/mdm_route.sv
module mdm_route (
    input  logic lpbk_en,
    input  logic man_rts,
    input  logic pol_hi,
    input  logic cts_sync,
    input  logic rx_pin,
    input  logic tx_ser,
    output logic rx_ser,
    output logic tx_pin,
    output logic rts_pin,
    output logic cts_eff
);
    logic cts_pin_active;
    logic rts_level_on;
    logic rts_level_off;

    always_comb begin
        // pin is active when it matches the selected polarity
        cts_pin_active = (cts_sync == pol_hi);
        rts_level_on   = pol_hi;
        rts_level_off  = ~pol_hi;

        tx_pin = tx_ser;
        if (lpbk_en) begin
            rx_ser  = tx_ser;
            rts_pin = rts_level_off;
            cts_eff = man_rts;
        end else begin
            rx_ser  = rx_pin;
            rts_pin = man_rts ? rts_level_on : rts_level_off;
            cts_eff = cts_pin_active;
        end
    end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic clr,
    output logic flag
);
    logic prev;
    logic moved;

    always_comb moved = (cur != prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            prev <= cur;
            if (moved)    flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/mdm_txgate.sv
module mdm_txgate
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cts,
    input  logic cts_eff,
    input  logic hold_valid,
    input  logic shift_done,
    output logic xfer_go,
    output logic tx_active
);
    gate_st_t st_q, st_d;
    logic     path_clear;

    always_comb path_clear = ~auto_cts | cts_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_valid && path_clear)  st_d = ST_SHIFT;   // launch
                else if (hold_valid)           st_d = ST_BLOCKED; // stall
            end
            ST_BLOCKED: begin
                if (path_clear)                st_d = ST_SHIFT;   // release
            end
            ST_SHIFT: begin
                if (shift_done)                st_d = ST_IDLE;    // finish
            end
            default:                           st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        xfer_go   = 1'b0;
        tx_active = 1'b0;
        unique case (st_q)
            ST_IDLE:    xfer_go   = hold_valid & path_clear;
            ST_BLOCKED: xfer_go   = path_clear;
            ST_SHIFT:   tx_active = 1'b1;
            default: begin
                xfer_go   = 1'b0;
                tx_active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lpbk_en,
    input  logic man_rts,
    input  logic auto_cts,
    input  logic pol_hi,
    input  logic dcts_clr,
    input  logic cts_pin,
    input  logic rx_pin,
    input  logic tx_ser,
    input  logic hold_valid,
    input  logic shift_done,
    output logic rx_ser,
    output logic tx_pin,
    output logic rts_pin,
    output logic xfer_go,
    output logic tx_active,
    output logic cts_stat,
    output logic dcts_stat
);
    logic cts_sync;
    logic cts_eff;

    mdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_pin),
        .q     (cts_sync)
    );

    mdm_route u_route (
        .lpbk_en  (lpbk_en),
        .man_rts  (man_rts),
        .pol_hi   (pol_hi),
        .cts_sync (cts_sync),
        .rx_pin   (rx_pin),
        .tx_ser   (tx_ser),
        .rx_ser   (rx_ser),
        .tx_pin   (tx_pin),
        .rts_pin  (rts_pin),
        .cts_eff  (cts_eff)
    );

    mdm_delta u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cts_eff),
        .clr   (dcts_clr),
        .flag  (dcts_stat)
    );

    mdm_txgate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_cts   (auto_cts),
        .cts_eff    (cts_eff),
        .hold_valid (hold_valid),
        .shift_done (shift_done),
        .xfer_go    (xfer_go),
        .tx_active  (tx_active)
    );

    assign cts_stat = cts_eff;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
    input logic clk,
    input logic rst_n,
    input logic lpbk_en,
    input logic pol_hi,
    input logic auto_cts,
    input logic dcts_clr,
    input logic tx_ser,
    input logic shift_done,
    input logic rx_ser,
    input logic rts_pin,
    input logic xfer_go,
    input logic tx_active,
    input logic cts_stat,
    input logic dcts_stat
);
    // R1
    loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en |-> rx_ser == tx_ser);

    // R3
    loop_rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en |-> rts_pin == ~pol_hi);

    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts && !cts_stat) |-> !xfer_go);

    // R8
    frame_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> tx_active);

    // R8
    frame_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !shift_done) |=> tx_active);

    // R9
    delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_stat != $past(cts_stat)) |=> dcts_stat);

    // R9
    delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcts_stat && !dcts_clr) |=> dcts_stat);
endmodule

bind uart_modem_ctl mdm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpbk_en    (lpbk_en),
    .pol_hi     (pol_hi),
    .auto_cts   (auto_cts),
    .dcts_clr   (dcts_clr),
    .tx_ser     (tx_ser),
    .shift_done (shift_done),
    .rx_ser     (rx_ser),
    .rts_pin    (rts_pin),
    .xfer_go    (xfer_go),
    .tx_active  (tx_active),
    .cts_stat   (cts_stat),
    .dcts_stat  (dcts_stat)
);

// File: tb/tb_uart_modem_ctl.sv
`timescale 1ns/1ps
module tb_uart_modem_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lpbk_en = 1'b0, man_rts = 1'b0, auto_cts = 1'b0, pol_hi = 1'b0;
    logic dcts_clr = 1'b0, cts_pin = 1'b1, rx_pin = 1'b0, tx_ser = 1'b0;
    logic hold_valid = 1'b0, shift_done = 1'b0;
    logic rx_ser, tx_pin, rts_pin, xfer_go, tx_active, cts_stat, dcts_stat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uart_modem_ctl #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .lpbk_en(lpbk_en), .man_rts(man_rts),
        .auto_cts(auto_cts), .pol_hi(pol_hi), .dcts_clr(dcts_clr),
        .cts_pin(cts_pin), .rx_pin(rx_pin), .tx_ser(tx_ser),
        .hold_valid(hold_valid), .shift_done(shift_done),
        .rx_ser(rx_ser), .tx_pin(tx_pin), .rts_pin(rts_pin),
        .xfer_go(xfer_go), .tx_active(tx_active),
        .cts_stat(cts_stat), .dcts_stat(dcts_stat)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // advance n edges, then settle 2 ns after the last one
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10 reset state
        #3;
        chk("R10 xfer_go", xfer_go, 1'b0);
        chk("R10 tx_active", tx_active, 1'b0);
        chk("R10 dcts_stat", dcts_stat, 1'b0);
        step(2);
        rst_n = 1'b1;
        step(4);

        // R1 R2 R3 R4 exhaustive sweep
        for (int i = 0; i < 64; i++) begin
            logic l, p, m, c, r, t, e_rx, e_rts, e_cts;
            {l, p, m, c, r, t} = 6'(i);
            lpbk_en = l; pol_hi = p; man_rts = m; cts_pin = c; rx_pin = r; tx_ser = t;
            step(3);
            e_rx  = l ? t : r;
            e_rts = l ? ~p : (m ? p : ~p);
            e_cts = l ? m : (c == p);
            chk("R1 rx_ser", rx_ser, e_rx);
            chk("R2 tx_pin", tx_pin, t);
            chk("R3 rts_pin", rts_pin, e_rts);
            chk("R4 cts_stat", cts_stat, e_cts);
        end

        // R5: gating off, CTS inactive, transfer still permitted
        lpbk_en = 1'b1; man_rts = 1'b0; auto_cts = 1'b0; pol_hi = 1'b0;
        step(1);
        hold_valid = 1'b1;
        #1;
        chk("R5 xfer_go", xfer_go, 1'b1);
        step(1);
        hold_valid = 1'b0;
        chk("R8 tx_active after launch", tx_active, 1'b1);
        shift_done = 1'b1;
        step(1);
        shift_done = 1'b0;
        chk("R8 finish", tx_active, 1'b0);

        // R6 R7: loopback gating by manual RTS
        auto_cts = 1'b1;
        hold_valid = 1'b1;
        #1;
        chk("R6 no launch", xfer_go, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk("R6 held", xfer_go, 1'b0);
            chk("R6 not shifting", tx_active, 1'b0);
        end
        man_rts = 1'b1;
        #1;
        chk("R7 release", xfer_go, 1'b1);
        step(1);
        hold_valid = 1'b0;
        chk("R7 shifting", tx_active, 1'b1);

        // R8: CTS drops mid-frame, frame completes
        man_rts = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk("R8 frame continues", tx_active, 1'b1);
        end
        shift_done = 1'b1;
        step(1);
        shift_done = 1'b0;
        chk("R8 frame ends", tx_active, 1'b0);

        // R4 R7: gating through pin, active-high polarity, sync delay
        lpbk_en = 1'b0; pol_hi = 1'b1; cts_pin = 1'b0;
        step(3);
        hold_valid = 1'b1;
        step(1);
        chk("R6 pin blocked", xfer_go, 1'b0);
        cts_pin = 1'b1;
        step(1);
        chk("R4 one edge not yet", xfer_go, 1'b0);
        step(1);
        chk("R7 pin release", xfer_go, 1'b1);
        step(1);
        hold_valid = 1'b0;
        chk("R8 pin shifting", tx_active, 1'b1);
        shift_done = 1'b1;
        step(1);
        shift_done = 1'b0;

        // R9 delta flag
        lpbk_en = 1'b1; man_rts = 1'b0;
        step(2);
        dcts_clr = 1'b1;
        step(1);
        dcts_clr = 1'b0;
        chk("R9 cleared", dcts_stat, 1'b0);
        man_rts = 1'b1;
        step(1);
        chk("R9 set on change", dcts_stat, 1'b1);
        step(4);
        chk("R9 sticky", dcts_stat, 1'b1);
        dcts_clr = 1'b1;
        step(1);
        dcts_clr = 1'b0;
        chk("R9 clear", dcts_stat, 1'b0);
        man_rts = 1'b0;
        dcts_clr = 1'b1;
        step(1);
        dcts_clr = 1'b0;
        chk("R9 set wins", dcts_stat, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule